// File: doc/BRIEF.md
# Trap and Reset Vector Arbiter

This block decides, once per cycle, which exception a small processor core services next. It sees three reset sources (the external reset pin, a software reset command and a watchdog overflow), three hardware trap requests (non-maskable interrupt, stack overflow and stack underflow), and one regular interrupt that is already resolved, given as a pending flag, a level and its trap number. The block registers the winner and presents it as a valid strobe, a vector address, a trap number and a priority class. The core acknowledges the grant to release the next one.

Resets form the top class. The three hardware traps form the middle class. No enable masks them, and they beat a regular interrupt at any level. A regular interrupt is the lowest class. Each hardware trap also sets a sticky status flag, which software clears by writing ones.

Top module: `excArbiter`

## Requirements
- R1: When any reset source is asserted, the next grant is vector 0x000000, trap number 0x00, class 3. This holds whatever traps or interrupts are pending.
- R2: A non-maskable interrupt request alone is granted as vector 0x000008, trap number 0x02, class 2.
- R3: A stack overflow request is granted as vector 0x000010, trap number 0x04, class 2.
- R4: A stack underflow request is granted as vector 0x000018, trap number 0x06, class 2.
- R5: Among simultaneous hardware traps, the non-maskable interrupt wins first, then stack overflow, then stack underflow.
- R6: A pending hardware trap beats a pending regular interrupt, even at the highest interrupt level (15).
- R7: A regular interrupt with a nonzero level is granted with class 1. Its trap number is passed through, and its vector is that number times 4. An interrupt at level 0 is never granted.
- R8: The outputs are registered. A valid grant holds all its fields until `ack` is high at a clock edge, and the next winner is sampled at that edge. When nothing is pending at the sampling edge, the valid strobe drops and the fields read 0.
- R9: `trapFlags` bit 0 (non-maskable interrupt), bit 1 (stack overflow) and bit 2 (stack underflow) are set by their requests and stay set. A write with `clrWe` high clears every bit whose `clrData` bit is 1, and leaves bits written with 0 unchanged. A request arriving at the same edge as a clear keeps its bit set.
- R10: While any reset source is asserted, all flags are cleared and no trap or interrupt is granted. A held grant that is not a reset grant is replaced by the reset grant at the next edge, without waiting for `ack`.
- R11: After `rstN` is released, the valid strobe is low and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| hwRstReq | input | 1 | External reset pin request |
| swRstReq | input | 1 | Software reset request |
| wdtRstReq | input | 1 | Watchdog overflow reset request |
| nmiReq | input | 1 | Non-maskable interrupt trap request |
| stkOvfReq | input | 1 | Stack overflow trap request |
| stkUnfReq | input | 1 | Stack underflow trap request |
| irqPend | input | 1 | Regular interrupt pending |
| irqLevel | input | LVL_W | Level of the pending interrupt |
| irqNum | input | TRAP_W | Trap number of the pending interrupt |
| ack | input | 1 | Core accepts the current grant |
| clrWe | input | 1 | Flag clear write strobe |
| clrData | input | 3 | Write-one-to-clear mask for the flags |
| excValid | output | 1 | Grant valid |
| excVector | output | ADDR_W | Vector address of the grant |
| excTrapNum | output | TRAP_W | Trap number of the grant |
| excClass | output | 2 | Priority class: 3 reset, 2 hardware trap, 1 interrupt, 0 none |
| trapFlags | output | 3 | Sticky hardware trap flags |

## Verification
Two pairs of events can collide at one clock edge.

The first pair is a flag clear and a new trap event. The bench writes a clear mask that covers the bit of a trap requested at that same edge, together with an unrelated bit. It then expects the requested bit to survive and the unrelated bit to fall.

The second pair is a held, unacknowledged trap grant and a newly asserted reset source. The bench keeps `ack` low and expects the reset grant to replace the trap grant at the very next edge, with all flags cleared. The reset grant must then stay put while other reset sources and traps keep arriving.

// File: rtl/excPkg.sv
package excPkg;
  localparam int TRAP_SRCS = 3;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_IRQ   = 2'd1,
    CLS_TRAP  = 2'd2,
    CLS_RESET = 2'd3
  } excClass_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                 load;
    logic                 selReset;
    logic [TRAP_SRCS-1:0] selTrap;
    logic                 selIrq;
    logic                 flush;
    logic [TRAP_SRCS-1:0] setMask;
    logic [TRAP_SRCS-1:0] clrMask;
  } arbStrobe_t;
endpackage

// File: rtl/excArbCtrl.sv
module excArbCtrl
  import excPkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic [2:0]           rstSrc,
  input  logic [TRAP_SRCS-1:0] trapReq,
  input  logic                 irqPend,
  input  logic [LVL_W-1:0]     irqLevel,
  input  logic                 ack,
  input  logic                 clrWe,
  input  logic [TRAP_SRCS-1:0] clrData,
  input  logic                 curValid,
  input  logic [1:0]           curClass,
  output arbStrobe_t           strb
);
  logic                 rstAny;
  logic                 irqOk;
  logic [TRAP_SRCS-1:0] trapPick;

  // fixed priority: lowest index wins
  always_comb begin
    trapPick = '0;
    for (int i = TRAP_SRCS - 1; i >= 0; i--) begin
      if (trapReq[i]) trapPick = TRAP_SRCS'(1) << i;
    end
  end

  always_comb begin
    rstAny        = |rstSrc;
    irqOk         = irqPend && (irqLevel != '0);
    strb.load     = !curValid || ack || (rstAny && (curClass != CLS_RESET));
    strb.selReset = rstAny;
    strb.selTrap  = rstAny ? '0 : trapPick;
    strb.selIrq   = !rstAny && !(|trapReq) && irqOk;
    strb.flush    = rstAny;
    strb.setMask  = trapReq;
    strb.clrMask  = clrWe ? clrData : '0;
  end
endmodule

// File: rtl/excArbPath.sv
module excArbPath
  import excPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int TRAP_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  arbStrobe_t           strb,
  input  logic [TRAP_W-1:0]    irqNum,
  output logic                 excValid,
  output logic [ADDR_W-1:0]    excVector,
  output logic [TRAP_W-1:0]    excTrapNum,
  output logic [1:0]           excClass,
  output logic [TRAP_SRCS-1:0] trapFlags
);
  logic              nextValid;
  logic [TRAP_W-1:0] nextTn;
  logic [1:0]        nextClass;

  always_comb begin
    nextValid = 1'b0;
    nextTn    = '0;
    nextClass = CLS_NONE;
    if (strb.selReset) begin
      nextValid = 1'b1;
      nextClass = CLS_RESET;
    end else if (|strb.selTrap) begin
      nextValid = 1'b1;
      nextClass = CLS_TRAP;
      // trap source i maps to trap number 2*(i+1)
      for (int i = 0; i < TRAP_SRCS; i++) begin
        if (strb.selTrap[i]) nextTn = TRAP_W'(2 * (i + 1));
      end
    end else if (strb.selIrq) begin
      nextValid = 1'b1;
      nextClass = CLS_IRQ;
      nextTn    = irqNum;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      excValid   <= 1'b0;
      excVector  <= '0;
      excTrapNum <= '0;
      excClass   <= CLS_NONE;
    end else if (strb.load) begin
      excValid   <= nextValid;
      excTrapNum <= nextTn;
      excVector  <= ADDR_W'(nextTn) << 2;
      excClass   <= nextClass;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) trapFlags <= '0;
    else if (strb.flush) trapFlags <= '0;
    else trapFlags <= (trapFlags & ~strb.clrMask) | strb.setMask;
  end
endmodule

// File: rtl/excArbiter.sv
module excArbiter
  import excPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int TRAP_W = 8,
  parameter int LVL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hwRstReq,
  input  logic              swRstReq,
  input  logic              wdtRstReq,
  input  logic              nmiReq,
  input  logic              stkOvfReq,
  input  logic              stkUnfReq,
  input  logic              irqPend,
  input  logic [LVL_W-1:0]  irqLevel,
  input  logic [TRAP_W-1:0] irqNum,
  input  logic              ack,
  input  logic              clrWe,
  input  logic [2:0]        clrData,
  output logic              excValid,
  output logic [ADDR_W-1:0] excVector,
  output logic [TRAP_W-1:0] excTrapNum,
  output logic [1:0]        excClass,
  output logic [2:0]        trapFlags
);
  arbStrobe_t strb;

  excArbCtrl #(.LVL_W(LVL_W)) uCtrl (
    .rstSrc   ({wdtRstReq, swRstReq, hwRstReq}),
    .trapReq  ({stkUnfReq, stkOvfReq, nmiReq}),
    .irqPend  (irqPend),
    .irqLevel (irqLevel),
    .ack      (ack),
    .clrWe    (clrWe),
    .clrData  (clrData),
    .curValid (excValid),
    .curClass (excClass),
    .strb     (strb)
  );

  excArbPath #(.ADDR_W(ADDR_W), .TRAP_W(TRAP_W)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .irqNum     (irqNum),
    .excValid   (excValid),
    .excVector  (excVector),
    .excTrapNum (excTrapNum),
    .excClass   (excClass),
    .trapFlags  (trapFlags)
  );
endmodule

// File: rtl/excArbiterChk.sv
module excArbiterChk #(
  parameter int ADDR_W = 24,
  parameter int TRAP_W = 8,
  parameter int LVL_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              hwRstReq,
  input logic              swRstReq,
  input logic              wdtRstReq,
  input logic              nmiReq,
  input logic              stkOvfReq,
  input logic              stkUnfReq,
  input logic              irqPend,
  input logic [LVL_W-1:0]  irqLevel,
  input logic [TRAP_W-1:0] irqNum,
  input logic              ack,
  input logic              clrWe,
  input logic [2:0]        clrData,
  input logic              excValid,
  input logic [ADDR_W-1:0] excVector,
  input logic [TRAP_W-1:0] excTrapNum,
  input logic [1:0]        excClass,
  input logic [2:0]        trapFlags
);
  logic rstAny;
  logic anyTrap;
  logic canLoad;
  assign rstAny  = hwRstReq | swRstReq | wdtRstReq;
  assign anyTrap = nmiReq | stkOvfReq | stkUnfReq;
  assign canLoad = !excValid || ack;

  // R1
  reset_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstAny && canLoad |=> excValid && excClass == 2'd3 && excVector == '0);

  // R6
  trap_over_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq && irqPend && !rstAny && canLoad |=> excClass == 2'd2 && excTrapNum == TRAP_W'(2));

  // R7
  irq_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPend && irqLevel != '0 && !anyTrap && !rstAny && canLoad
    |=> excClass == 2'd1 && excTrapNum == $past(irqNum));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    excValid && !ack && !rstAny |=> excValid && $stable(excVector) && $stable(excTrapNum));

  // R9
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq && !rstAny |=> trapFlags[0]);

  // R9
  w1c_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrWe && clrData[1] && !stkOvfReq && !rstAny |=> !trapFlags[1]);

  // R10
  flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstAny |=> trapFlags == 3'b000 && excClass == 2'd3);
endmodule

bind excArbiter excArbiterChk #(.ADDR_W(ADDR_W), .TRAP_W(TRAP_W), .LVL_W(LVL_W)) uChk (.*);

// File: tb/sim_excArbiter.sv
module sim_excArbiter;
  localparam int ADDR_W = 24;
  localparam int TRAP_W = 8;
  localparam int LVL_W  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hw, sw, wdt, nmi, ovf, unf, irqP, ack, clrWe;
  logic [LVL_W-1:0]  lvl;
  logic [TRAP_W-1:0] num;
  logic [2:0]        clrD;
  logic              excValid;
  logic [ADDR_W-1:0] excVector;
  logic [TRAP_W-1:0] excTrapNum;
  logic [1:0]        excClass;
  logic [2:0]        trapFlags;

  typedef struct {
    string             tag;
    logic              v;
    logic [ADDR_W-1:0] vec;
    logic [TRAP_W-1:0] tn;
    logic [1:0]        cl;
    logic [2:0]        fl;
  } item_t;

  item_t expQ[$];
  int nRun = 0;
  int nFail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  excArbiter #(.ADDR_W(ADDR_W), .TRAP_W(TRAP_W), .LVL_W(LVL_W)) u0 (
    .clk(clk), .rstN(rstN), .hwRstReq(hw), .swRstReq(sw), .wdtRstReq(wdt),
    .nmiReq(nmi), .stkOvfReq(ovf), .stkUnfReq(unf), .irqPend(irqP),
    .irqLevel(lvl), .irqNum(num), .ack(ack), .clrWe(clrWe), .clrData(clrD),
    .excValid(excValid), .excVector(excVector), .excTrapNum(excTrapNum),
    .excClass(excClass), .trapFlags(trapFlags)
  );

  task automatic idle();
    hw = 0; sw = 0; wdt = 0; nmi = 0; ovf = 0; unf = 0;
    irqP = 0; ack = 0; clrWe = 0; lvl = '0; num = '0; clrD = '0;
  endtask

  // driver: clock one edge, then queue the result expected after it
  task automatic step(string tag, logic v, logic [ADDR_W-1:0] vec,
                      logic [TRAP_W-1:0] tn, logic [1:0] cl, logic [2:0] fl);
    item_t it;
    @(posedge clk);
    it.tag = tag; it.v = v; it.vec = vec; it.tn = tn; it.cl = cl; it.fl = fl;
    expQ.push_back(it);
    @(negedge clk);
  endtask

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      item_t e;
      e = expQ.pop_front();
      nRun++;
      if (excValid !== e.v || excVector !== e.vec || excTrapNum !== e.tn ||
          excClass !== e.cl || trapFlags !== e.fl) begin
        nFail++;
        $display("FAIL %s: got v=%0b vec=%h tn=%h cl=%0d fl=%b, exp v=%0b vec=%h tn=%h cl=%0d fl=%b",
                 e.tag, excValid, excVector, excTrapNum, excClass, trapFlags,
                 e.v, e.vec, e.tn, e.cl, e.fl);
      end
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11: reset state
    nRun++;
    if (excValid !== 1'b0 || trapFlags !== 3'b000) begin
      nFail++;
      $display("FAIL R11: got v=%0b fl=%b, exp v=0 fl=000", excValid, trapFlags);
    end

    nmi = 1;
    step("R2 nmi grant", 1, 24'h000008, 8'h02, 2'd2, 3'b001);
    nmi = 0; ovf = 1;
    step("R8 hold without ack", 1, 24'h000008, 8'h02, 2'd2, 3'b011);
    ovf = 0; ack = 1;
    step("R8 ack with nothing pending", 0, '0, '0, 2'd0, 3'b011);
    ack = 0; ovf = 1; unf = 1;
    step("R5 R3 ovf before unf", 1, 24'h000010, 8'h04, 2'd2, 3'b111);
    ack = 1; ovf = 0;
    step("R4 unf grant", 1, 24'h000018, 8'h06, 2'd2, 3'b111);
    unf = 0; nmi = 1; irqP = 1; lvl = 4'd15; num = 8'h2A;
    step("R6 trap beats level 15 irq", 1, 24'h000008, 8'h02, 2'd2, 3'b111);
    nmi = 0;
    step("R7 irq pass through", 1, 24'h0000A8, 8'h2A, 2'd1, 3'b111);
    lvl = 4'd0;
    step("R7 level 0 not granted", 0, '0, '0, 2'd0, 3'b111);
    irqP = 0; clrWe = 1; clrD = 3'b101; nmi = 1;
    step("R9 set beats clear, w1c", 1, 24'h000008, 8'h02, 2'd2, 3'b011);
    clrD = 3'b000; nmi = 0; ack = 0;
    step("R9 write zero no effect", 1, 24'h000008, 8'h02, 2'd2, 3'b011);
    clrWe = 0; wdt = 1;
    step("R10 R1 watchdog preempts held trap", 1, '0, '0, 2'd3, 3'b000);
    wdt = 0; sw = 1; ovf = 1; irqP = 1; lvl = 4'd5;
    step("R10 reset suppresses trap and irq", 1, '0, '0, 2'd3, 3'b000);
    sw = 0; hw = 1; ack = 1; ovf = 0; nmi = 1;
    step("R1 pin reset beats nmi", 1, '0, '0, 2'd3, 3'b000);
    hw = 0; nmi = 0; irqP = 0; lvl = '0;
    step("R8 idle after ack", 0, '0, '0, 2'd0, 3'b000);
    idle();
    @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule